// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock

This block is a bus-attached calendar clock. It holds seconds, minutes, hours, day of month, month and a two-digit year. Each counter is one packed-BCD byte that software can read or load through a single-cycle byte bus. A one-second tick input moves the calendar forward. The tick ripples through the fields, following month lengths and the leap rule for a two-digit year.

Two control registers sit beside the counters. The run-control register holds a stop bit and two bits that must both be one for counting to run. The carry register holds the carry flag and the carry-interrupt enable. The carry flag is set on every counted tick. To take a coherent snapshot, software writes zero to the carry register, reads the six counters, then reads the carry register. If the flag is set, a count happened during the read, so software repeats the sequence.

A two-state sequencer governs counting. ST_STOP is entered at reset and on any run-control write that has the stop bit set, or that does not have both the enable and start bits set. ST_RUN is entered from either state on a run-control write with the stop bit clear and both the enable and start bits set.

Top module: `bcd_rtc`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 00, day and month read 01, and the carry register and the run-control register read 00.
- R2: The counters sit at byte addresses 0 (seconds), 1 (minutes), 2 (hours), 3 (day), 4 (month) and 5 (year). A write with bus_sel and bus_we high loads the BCD byte, and it reads back from the next cycle.
- R3: In ST_RUN, a tick high for one cycle adds one to the seconds in BCD, so 09 becomes 10 and 56 becomes 57.
- R4: Seconds wrap from 59 to 00 and add one to minutes. Minutes wrap from 59 to 00 and add one to hours. Hours wrap from 23 to 00 and add one to the day.
- R5: The day wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in months 01, 03, 05, 07, 08, 10 and 12. Each wrap adds one to the month. Month 12 wraps to 01 and adds one to the year. Year 99 wraps to 00.
- R6: February ends at day 29 when the two-digit year is divisible by four, year 00 included, and at day 28 otherwise.
- R7: Run control is at address 7. Bit 0 is stop, bit 1 is enable and bit 2 is start. A write with bit 0 set enters ST_STOP. A write with bit 0 clear and bits 1 and 2 both set enters ST_RUN. Any other write enters ST_STOP. The register reads 0x06 in ST_RUN and 0x00 in ST_STOP.
- R8: In ST_STOP, ticks leave every counter unchanged.
- R9: The carry register is at address 6. Bit 0 is the carry flag and bit 1 is the carry-interrupt enable. Every counted tick sets the flag.
- R10: A write to address 6 with bit 0 clear clears the flag and loads bit 1 into the enable. If a counted tick falls in the same cycle, the flag is set.
- R11: carry_irq is high exactly when the carry flag and the carry-interrupt enable are both set.
- R12: A counter write in the same cycle as a tick takes the written value, and that tick is dropped for all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Byte register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| carry_irq | output | 1 | Carry interrupt request |

## Verification
The counter assertions assume software loads only legal BCD values. Under that assumption, a field at or above its limit always wraps to its low value, and writes never leave a field outside its range. The bench loads only valid BCD calendar dates, and it makes every load with the clock in ST_STOP unless the case being tested is a write that collides with a tick. Ticks are one cycle wide and arrive no faster than one per cycle, so each counted tick is a single increment.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int NFIELDS = 6;

    localparam logic [ADDR_W-1:0] A_CARRY = 3'd6;
    localparam logic [ADDR_W-1:0] A_RUN   = 3'd7;
    localparam int DAY_IDX = 3;

    typedef enum logic [0:0] {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    function automatic logic [BYTE_W-1:0] field_low(input int idx);
        return (idx == 3 || idx == 4) ? 8'h01 : 8'h00;
    endfunction

    function automatic logic [BYTE_W-1:0] field_high(input int idx);
        case (idx)
            0, 1:    return 8'h59;
            2:       return 8'h23;
            4:       return 8'h12;
            default: return 8'h99;
        endcase
    endfunction

    function automatic logic leap_bcd(input logic [BYTE_W-1:0] yr);
        logic [1:0] s;
        s = {yr[4], 1'b0} + yr[1:0];
        return (s == 2'b00);
    endfunction
endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len
    import rtc_pkg::*;
(
    input  logic [BYTE_W-1:0] month,
    input  logic [BYTE_W-1:0] year,
    output logic [BYTE_W-1:0] last_day
);
    always_comb begin
        unique case (month)
            8'h02:                      last_day = leap_bcd(year) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
    import rtc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RST_VAL = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              inc,
    input  logic [BYTE_W-1:0] lo,
    input  logic [BYTE_W-1:0] hi,
    output logic [BYTE_W-1:0] q
);
    logic [BYTE_W-1:0] q_next;

    always_comb begin
        q_next = q;
        if (wr_en)
            q_next = wdata;
        else if (inc) begin
            if (q >= hi)
                q_next = lo;
            else if (q[3:0] >= 4'd9)
                q_next = {q[7:4] + 4'd1, 4'd0};
            else
                q_next = {q[7:4], q[3:0] + 4'd1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= q_next;
    end

    AST_WRAP_TO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_en && q >= hi) |=> (q == $past(lo))) else $error("wrap"); // R4
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(wdata))) else $error("load"); // R2
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_we,
    input  logic run_stop_bit,
    input  logic run_en_bit,
    input  logic run_start_bit,
    input  logic carry_we,
    input  logic carry_keep_bit,
    input  logic carry_ie_bit,
    input  logic adv,
    output logic running,
    output logic carry_flag,
    output logic carry_ie,
    output logic irq
);
    run_state_t state, state_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STOP;
        else        state <= state_next;
    end

    always_comb begin
        state_next = state;
        unique case (state)
            ST_STOP: if (run_we && !run_stop_bit && run_en_bit && run_start_bit)
                         state_next = ST_RUN;
            ST_RUN:  if (run_we && (run_stop_bit || !run_en_bit || !run_start_bit))
                         state_next = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_flag <= 1'b0;
            carry_ie   <= 1'b0;
        end else begin
            if (carry_we) carry_ie <= carry_ie_bit;
            carry_flag <= adv | (carry_flag & (!carry_we | carry_keep_bit));
        end
    end

    always_comb begin
        running = (state == ST_RUN);
        irq     = carry_flag & carry_ie;
    end

    AST_CARRY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> carry_flag) else $error("carry set"); // R9
    AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_we && !carry_keep_bit && !adv) |=> !carry_flag) else $error("carry clr"); // R10
    AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_we && run_stop_bit) |=> (state == ST_STOP)) else $error("stop"); // R7
    AST_ADV_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (state == ST_RUN)) else $error("adv"); // R8
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              carry_irq
);
    logic                wr;
    logic                cnt_wr;
    logic                running, cflag, cie, adv;
    logic [BYTE_W-1:0]   q_v  [NFIELDS];
    logic [BYTE_W-1:0]   hi_v [NFIELDS];
    logic [NFIELDS-1:0]  inc_v;
    logic [BYTE_W-1:0]   last_day;

    assign wr     = bus_sel & bus_we;
    assign cnt_wr = wr && (int'(bus_addr) < NFIELDS);
    assign adv    = running & tick_1hz & ~cnt_wr;

    rtc_month_len u_mlen (
        .month    (q_v[4]),
        .year     (q_v[5]),
        .last_day (last_day)
    );

    assign inc_v[0] = adv;

    for (genvar i = 0; i < NFIELDS; i++) begin : g_field
        if (i == DAY_IDX) begin : g_day
            assign hi_v[i] = last_day;
        end else begin : g_fix
            assign hi_v[i] = field_high(i);
        end
        if (i > 0) begin : g_chain
            assign inc_v[i] = inc_v[i-1] & (q_v[i-1] >= hi_v[i-1]);
        end
        rtc_bcd_field #(.RST_VAL(field_low(i))) u_fld (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr && (bus_addr == ADDR_W'(i))),
            .wdata (bus_wdata),
            .inc   (inc_v[i]),
            .lo    (field_low(i)),
            .hi    (hi_v[i]),
            .q     (q_v[i])
        );
    end

    rtc_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .run_we         (wr && bus_addr == A_RUN),
        .run_stop_bit   (bus_wdata[0]),
        .run_en_bit     (bus_wdata[1]),
        .run_start_bit  (bus_wdata[2]),
        .carry_we       (wr && bus_addr == A_CARRY),
        .carry_keep_bit (bus_wdata[0]),
        .carry_ie_bit   (bus_wdata[1]),
        .adv            (adv),
        .running        (running),
        .carry_flag     (cflag),
        .carry_ie       (cie),
        .irq            (carry_irq)
    );

    always_comb begin
        if (bus_addr == A_RUN)
            bus_rdata = {5'd0, running, running, 1'b0};
        else if (bus_addr == A_CARRY)
            bus_rdata = {6'd0, cie, cflag};
        else
            bus_rdata = q_v[bus_addr];
    end

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_wr) |=> $stable(q_v[0])) else $error("held"); // R8
    AST_WRITE_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 3'd0) |=> (q_v[0] == $past(bus_wdata))) else $error("wbt"); // R12
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (cflag && cie) |-> carry_irq) else $error("irq"); // R11
endmodule

// File: tb/bcd_rtc_test.sv
module bcd_rtc_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       carry_irq;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bcd_rtc uut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .carry_irq(carry_irq)
    );

    // {yr,mon,day,hr,min,sec} before one tick, then after
    localparam int NV = 12;
    localparam logic [95:0] VEC [NV] = '{
        {48'h70_01_01_00_00_09, 48'h70_01_01_00_00_10},
        {48'h70_01_01_00_00_59, 48'h70_01_01_00_01_00},
        {48'h70_01_01_23_59_59, 48'h70_01_02_00_00_00},
        {48'h70_01_31_23_59_59, 48'h70_02_01_00_00_00},
        {48'h70_04_30_23_59_59, 48'h70_05_01_00_00_00},
        {48'h71_02_28_23_59_59, 48'h71_03_01_00_00_00},
        {48'h72_02_28_23_59_59, 48'h72_02_29_00_00_00},
        {48'h72_02_29_23_59_59, 48'h72_03_01_00_00_00},
        {48'h99_12_31_23_59_59, 48'h00_01_01_00_00_00},
        {48'h00_02_28_23_59_59, 48'h00_02_29_00_00_00},
        {48'h70_06_15_12_34_56, 48'h70_06_15_12_34_57},
        {48'h70_11_30_23_59_59, 48'h70_12_01_00_00_00}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input logic with_tick);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick_1hz = with_tick;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; tick_1hz = 1'b0;
    endtask

    task automatic tick_once();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic expect_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog got=hang exp=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 6; i++)
            expect_reg("R1", 3'(i), (i == 3 || i == 4) ? 8'h01 : 8'h00);
        expect_reg("R1", 3'd6, 8'h00);
        expect_reg("R1", 3'd7, 8'h00);

        // R8 tick while stopped
        tick_once();
        expect_reg("R8", 3'd0, 8'h00);

        // vector table: R2..R6
        for (int v = 0; v < NV; v++) begin
            bus_write(3'd7, 8'h01, 1'b0);
            for (int i = 0; i < 6; i++) begin
                bus_write(3'(i), VEC[v][48 + 8*i +: 8], 1'b0);
                expect_reg("R2", 3'(i), VEC[v][48 + 8*i +: 8]);
            end
            bus_write(3'd7, 8'h06, 1'b0);
            tick_once();
            bus_write(3'd7, 8'h01, 1'b0);
            for (int i = 0; i < 6; i++)
                expect_reg("R3 R4 R5 R6", 3'(i), VEC[v][8*i +: 8]);
        end

        // R7 run-control readback and enable-only case
        expect_reg("R7", 3'd7, 8'h00);
        bus_write(3'd0, 8'h10, 1'b0);
        bus_write(3'd7, 8'h02, 1'b0);
        expect_reg("R7", 3'd7, 8'h00);
        tick_once();
        expect_reg("R7", 3'd0, 8'h10);
        bus_write(3'd7, 8'h06, 1'b0);
        expect_reg("R7", 3'd7, 8'h06);
        bus_write(3'd7, 8'h07, 1'b0);
        expect_reg("R7", 3'd7, 8'h00);
        tick_once();
        expect_reg("R8", 3'd0, 8'h10);

        // R9/R10/R11 carry flag
        bus_write(3'd6, 8'h00, 1'b0);
        expect_reg("R10", 3'd6, 8'h00);
        bus_write(3'd7, 8'h06, 1'b0);
        tick_once();
        expect_reg("R9", 3'd6, 8'h01);
        @(negedge clk) #1 check("R11", {7'd0, carry_irq}, 8'h00);
        bus_write(3'd6, 8'h03, 1'b0);
        expect_reg("R9", 3'd6, 8'h03);
        @(negedge clk) #1 check("R11", {7'd0, carry_irq}, 8'h01);
        bus_write(3'd6, 8'h02, 1'b0);
        expect_reg("R10", 3'd6, 8'h02);
        @(negedge clk) #1 check("R11", {7'd0, carry_irq}, 8'h00);
        bus_write(3'd6, 8'h02, 1'b1);
        expect_reg("R10", 3'd6, 8'h03);

        // R12 write collides with tick
        bus_write(3'd0, 8'h59, 1'b0);
        bus_write(3'd1, 8'h07, 1'b0);
        bus_write(3'd0, 8'h59, 1'b1);
        expect_reg("R12", 3'd0, 8'h59);
        expect_reg("R12", 3'd1, 8'h07);
        bus_write(3'd6, 8'h00, 1'b0);
        bus_write(3'd2, 8'h05, 1'b1);
        expect_reg("R12", 3'd6, 8'h00);
        tick_once();
        expect_reg("R4", 3'd1, 8'h08);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule